// File: doc/BRIEF.md
# EEPROM Initialization Table Loader

This block runs once after each hard reset and turns a table held in a byte-wide EEPROM into a series of memory-mapped writes. It looks first at an auto-load enable input taken from the reset configuration. When that input is low, the block reports completion at once and never touches the EEPROM. When it is high, the block reads a 32-bit table pointer, then walks the table record by record. Each record yields one write on a generic write port. The walk ends at the record flagged as final.

Every record is 12 bytes long. It holds three big-endian 32-bit fields: the destination address, the data word and a control word. The control word carries a transfer size and the final-record flag. Destinations are passed through unchanged, so a record can reach any location: an indirect address/data register pair of a configuration block, a peripheral register, or plain memory. Byte enables are derived from the size code and the two low address bits. Data is never shifted between lanes.

Two conditions stop the walk with an error flag. The first is a pointer that lands inside the EEPROM area kept for reset configuration words. The second is a table that runs for the full record limit without any record flagged as final.

Top module: `boot_table_loader`

## Requirements
- R1: With `autoload_en` low at reset release, the block pulses `done` without issuing any EEPROM read or any write, and `err` stays low.
- R2: With `autoload_en` high, the table pointer is read as a big-endian 32-bit value from EEPROM bytes 4 to 7, highest byte at address 4.
- R3: Each record occupies 12 consecutive bytes starting at the pointer: address in bytes 0-3, data in bytes 4-7, control in bytes 8-11, each big-endian. Records are written in table order, and `wr_addr` and `wr_data` carry the fields unchanged.
- R4: The size code sits in control bits [1:0]. Code 00 (byte) gives `wr_be` = 1 << addr[1:0]. Code 01 (halfword) gives 4'b0011 when addr[1] is 0 and 4'b1100 when addr[1] is 1. Codes 10 (word) and 11 give 4'b1111. `wr_be[k]` covers `wr_data[8k+7:8k]`.
- R5: A record with control bit 31 set is written, and then the walk stops. No further EEPROM read or write follows. `done` pulses for exactly one cycle, and `busy` is high during the walk and low from the `done` cycle on.
- R6: A pointer below `RSV_BYTES` (default 0x40) sets `err`, pulses `done` and produces no write. A pointer equal to `RSV_BYTES` is accepted.
- R7: After `MAX_REC` (default 256) writes with no final flag seen, the block sets `err` and pulses `done`. A final flag on record number `MAX_REC` completes normally with `err` low.
- R8: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr`, `wr_data` and `wr_be` hold their values into the next cycle.
- R9: At most one EEPROM read is outstanding. `rom_req` is a one-cycle request and is not raised again until `rom_valid` has returned the byte.
- R10: While `rst_n` is low, `busy`, `done`, `err`, `wr_valid` and `rom_req` are low. A reset in the middle of a walk discards the partial record, and the next walk restarts from the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| autoload_en | input | 1 | Auto-load enable from the reset configuration |
| rom_req | output | 1 | One-cycle EEPROM byte read request |
| rom_addr | output | ROM_AW | EEPROM byte address, valid with `rom_req` |
| rom_valid | input | 1 | EEPROM read data valid |
| rom_data | input | 8 | EEPROM read byte |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted |
| wr_addr | output | 32 | Write destination address |
| wr_data | output | 32 | Write data |
| wr_be | output | 4 | Write byte enables |
| busy | output | 1 | Table walk in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky error: bad pointer or record limit reached |

## Verification
The final-record flag and the record limit can both apply to the same write handshake: record number `MAX_REC` may carry the flag, or it may be one more plain record. The bench builds two 256-record tables that differ only in that final control word. In the first, the completion must be clean with `err` low. In the second, `err` must be set. Both must show exactly 256 writes and a single `done` pulse. A second overlap tested is a write stall under a pending handshake. The bench withholds `wr_ready` on a fixed pattern and compares the write outputs across every stalled cycle.

// File: rtl/btl_pkg.sv
package btl_pkg;

   typedef enum logic [2:0] {
      ST_BOOT,
      ST_PTR,
      ST_ADDR,
      ST_DATA,
      ST_CTRL,
      ST_WRITE,
      ST_FIN,
      ST_HALT
   } btl_state_e;

   localparam int unsigned FIELD_BYTES = 4;
   localparam int unsigned REC_BYTES   = 3 * FIELD_BYTES;

   localparam logic [1:0] SZ_BYTE = 2'b00;
   localparam logic [1:0] SZ_HALF = 2'b01;
   localparam logic [1:0] SZ_WORD = 2'b10;

   localparam int unsigned LAST_BIT = 31;

endpackage

// File: rtl/btl_byte_fetch.sv
module btl_byte_fetch #(
   parameter int ROM_AW = 16,
   parameter int NBYTES = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  go,
   input  logic [ROM_AW-1:0]     start_addr,
   output logic                  rom_req,
   output logic [ROM_AW-1:0]     rom_addr,
   input  logic                  rom_valid,
   input  logic [7:0]            rom_data,
   output logic [8*NBYTES-1:0]   word,
   output logic                  fin
);
   localparam int CW = (NBYTES > 1) ? $clog2(NBYTES) : 1;
   localparam int WW = 8 * NBYTES;

   logic [ROM_AW-1:0] cur;
   logic [CW-1:0]     cnt;
   logic              issue;
   logic              pend;
   logic [WW-1:0]     shreg;
   logic              last_byte;

   assign last_byte = (cnt == CW'(NBYTES - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur   <= '0;
         cnt   <= '0;
         issue <= 1'b0;
         pend  <= 1'b0;
         shreg <= '0;
         fin   <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (go) begin
            cur   <= start_addr;
            cnt   <= '0;
            issue <= 1'b1;
            pend  <= 1'b0;
         end else if (issue) begin
            issue <= 1'b0;
            pend  <= 1'b1;
         end else if (pend && rom_valid) begin
            pend <= 1'b0;
            if (WW > 8) shreg <= {shreg[WW-9:0], rom_data};
            else        shreg <= WW'(rom_data);
            if (last_byte) begin
               fin <= 1'b1;
            end else begin
               cnt   <= cnt + 1'b1;
               cur   <= cur + 1'b1;
               issue <= 1'b1;
            end
         end
      end
   end

   assign rom_req  = issue;
   assign rom_addr = cur;
   assign word     = shreg;

   // R9: no new request while a read is still pending
   a_r9_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !rom_valid) |-> !rom_req);

endmodule

// File: rtl/btl_be_gen.sv
module btl_be_gen #(
   parameter bit BIG_LANES = 1'b0
) (
   input  logic [1:0] size,
   input  logic [1:0] low,
   output logic [3:0] be
);
   import btl_pkg::*;

   logic [3:0] nat;

   always_comb begin
      case (size)
         SZ_BYTE: nat = 4'b0001 << low;
         SZ_HALF: nat = low[1] ? 4'b1100 : 4'b0011;
         default: nat = 4'b1111;
      endcase
   end

   generate
      if (BIG_LANES) begin : g_big
         assign be = {nat[0], nat[1], nat[2], nat[3]};
      end else begin : g_little
         assign be = nat;
      end
   endgenerate

endmodule

// File: rtl/btl_seq.sv
module btl_seq #(
   parameter int ROM_AW    = 16,
   parameter int PTR_LOC   = 4,
   parameter int RSV_BYTES = 64,
   parameter int MAX_REC   = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              autoload_en,
   output logic              fetch_go,
   output logic [ROM_AW-1:0] fetch_addr,
   input  logic [31:0]       fetch_word,
   input  logic              fetch_fin,
   output logic              wr_valid,
   input  logic              wr_ready,
   output logic [31:0]       wr_addr,
   output logic [31:0]       wr_data,
   output logic [1:0]        wr_size,
   output logic              busy,
   output logic              done,
   output logic              err
);
   import btl_pkg::*;

   localparam int CNTW = $clog2(MAX_REC);
   localparam logic [ROM_AW-1:0] OFS_DATA = ROM_AW'(FIELD_BYTES);
   localparam logic [ROM_AW-1:0] OFS_CTRL = ROM_AW'(2 * FIELD_BYTES);
   localparam logic [ROM_AW-1:0] OFS_NEXT = ROM_AW'(REC_BYTES);

   btl_state_e        state;
   logic [ROM_AW-1:0] rec_ptr;
   logic [31:0]       addr_q;
   logic [31:0]       data_q;
   logic [1:0]        size_q;
   logic              last_q;
   logic [CNTW-1:0]   rec_cnt;
   logic              ptr_low;
   logic              at_limit;

   assign ptr_low  = (fetch_word < 32'(RSV_BYTES));
   assign at_limit = (rec_cnt == CNTW'(MAX_REC - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_BOOT;
         fetch_go   <= 1'b0;
         fetch_addr <= '0;
         rec_ptr    <= '0;
         addr_q     <= '0;
         data_q     <= '0;
         size_q     <= '0;
         last_q     <= 1'b0;
         rec_cnt    <= '0;
         err        <= 1'b0;
      end else begin
         fetch_go <= 1'b0;
         case (state)
            ST_BOOT: begin
               if (autoload_en) begin
                  fetch_go   <= 1'b1;
                  fetch_addr <= ROM_AW'(PTR_LOC);
                  state      <= ST_PTR;
               end else begin
                  state <= ST_FIN;
               end
            end
            ST_PTR: begin
               if (fetch_fin) begin
                  if (ptr_low) begin
                     err   <= 1'b1;
                     state <= ST_FIN;
                  end else begin
                     rec_ptr    <= fetch_word[ROM_AW-1:0];
                     fetch_addr <= fetch_word[ROM_AW-1:0];
                     fetch_go   <= 1'b1;
                     state      <= ST_ADDR;
                  end
               end
            end
            ST_ADDR: begin
               if (fetch_fin) begin
                  addr_q     <= fetch_word;
                  fetch_addr <= rec_ptr + OFS_DATA;
                  fetch_go   <= 1'b1;
                  state      <= ST_DATA;
               end
            end
            ST_DATA: begin
               if (fetch_fin) begin
                  data_q     <= fetch_word;
                  fetch_addr <= rec_ptr + OFS_CTRL;
                  fetch_go   <= 1'b1;
                  state      <= ST_CTRL;
               end
            end
            ST_CTRL: begin
               if (fetch_fin) begin
                  size_q <= fetch_word[1:0];
                  last_q <= fetch_word[LAST_BIT];
                  state  <= ST_WRITE;
               end
            end
            ST_WRITE: begin
               if (wr_ready) begin
                  if (last_q) begin
                     state <= ST_FIN;
                  end else if (at_limit) begin
                     err   <= 1'b1;
                     state <= ST_FIN;
                  end else begin
                     rec_cnt    <= rec_cnt + 1'b1;
                     rec_ptr    <= rec_ptr + OFS_NEXT;
                     fetch_addr <= rec_ptr + OFS_NEXT;
                     fetch_go   <= 1'b1;
                     state      <= ST_ADDR;
                  end
               end
            end
            ST_FIN:  state <= ST_HALT;
            default: state <= ST_HALT;
         endcase
      end
   end

   assign wr_valid = (state == ST_WRITE);
   assign wr_addr  = addr_q;
   assign wr_data  = data_q;
   assign wr_size  = size_q;
   assign busy     = (state == ST_PTR) || (state == ST_ADDR) || (state == ST_DATA) ||
                     (state == ST_CTRL) || (state == ST_WRITE);
   assign done     = (state == ST_FIN);

   // R1: disabled auto-load finishes cleanly at once
   a_r1_skip: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_BOOT && !autoload_en) |=> (done && !err));

   // R5: done is a single-cycle pulse and never overlaps busy
   a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r5_busy_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

   // R5: accepted final record ends the walk
   a_r5_last_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_ready && last_q) |=> (done && !busy && !err));

   // R6: pointer inside the reserved area ends with an error
   a_r6_bad_ptr: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PTR && fetch_fin && ptr_low) |=> (err && done && !wr_valid));

   // R7: record limit reached without a final flag
   a_r7_limit: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_ready && !last_q && at_limit) |=> (err && done));

endmodule

// File: rtl/boot_table_loader.sv
module boot_table_loader #(
   parameter int ROM_AW    = 16,
   parameter int PTR_LOC   = 4,
   parameter int RSV_BYTES = 64,
   parameter int MAX_REC   = 256,
   parameter bit BIG_LANES = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              autoload_en,
   output logic              rom_req,
   output logic [ROM_AW-1:0] rom_addr,
   input  logic              rom_valid,
   input  logic [7:0]        rom_data,
   output logic              wr_valid,
   input  logic              wr_ready,
   output logic [31:0]       wr_addr,
   output logic [31:0]       wr_data,
   output logic [3:0]        wr_be,
   output logic              busy,
   output logic              done,
   output logic              err
);
   localparam int WORD_BYTES = 4;

   generate
      if (ROM_AW < 4 || ROM_AW > 32) begin : g_bad_aw
         $error("boot_table_loader: ROM_AW must lie in 4..32");
      end
      if (MAX_REC < 2) begin : g_bad_max
         $error("boot_table_loader: MAX_REC must be at least 2");
      end
      if (PTR_LOC + WORD_BYTES > RSV_BYTES) begin : g_bad_rsv
         $error("boot_table_loader: pointer must lie inside the reserved area");
      end
   endgenerate

   logic              f_go;
   logic [ROM_AW-1:0] f_addr;
   logic [31:0]       f_word;
   logic              f_fin;
   logic [1:0]        w_size;

   btl_byte_fetch #(
      .ROM_AW (ROM_AW),
      .NBYTES (WORD_BYTES)
   ) u_fetch (
      .clk        (clk),
      .rst_n      (rst_n),
      .go         (f_go),
      .start_addr (f_addr),
      .rom_req    (rom_req),
      .rom_addr   (rom_addr),
      .rom_valid  (rom_valid),
      .rom_data   (rom_data),
      .word       (f_word),
      .fin        (f_fin)
   );

   btl_seq #(
      .ROM_AW    (ROM_AW),
      .PTR_LOC   (PTR_LOC),
      .RSV_BYTES (RSV_BYTES),
      .MAX_REC   (MAX_REC)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .autoload_en (autoload_en),
      .fetch_go    (f_go),
      .fetch_addr  (f_addr),
      .fetch_word  (f_word),
      .fetch_fin   (f_fin),
      .wr_valid    (wr_valid),
      .wr_ready    (wr_ready),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .wr_size     (w_size),
      .busy        (busy),
      .done        (done),
      .err         (err)
   );

   btl_be_gen #(
      .BIG_LANES (BIG_LANES)
   ) u_be (
      .size (w_size),
      .low  (wr_addr[1:0]),
      .be   (wr_be)
   );

   // R8: stalled write request holds steady
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) &&
                                   $stable(wr_data) && $stable(wr_be)));

   // R4: byte enables always form one, two or four lanes
   a_r4_be_shape: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> ($countones(wr_be) == 1 || $countones(wr_be) == 2 ||
                    $countones(wr_be) == 4));

endmodule

// File: tb/boot_table_loader_test.sv
module boot_table_loader_test;
   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          autoload_en = 1'b0;
   logic          rom_req;
   logic [AW-1:0] rom_addr;
   logic          rom_valid = 1'b0;
   logic [7:0]    rom_data = 8'h00;
   logic          wr_valid;
   logic          wr_ready = 1'b1;
   logic [31:0]   wr_addr;
   logic [31:0]   wr_data;
   logic [3:0]    wr_be;
   logic          busy;
   logic          done;
   logic          err;

   boot_table_loader uut (
      .clk(clk), .rst_n(rst_n), .autoload_en(autoload_en),
      .rom_req(rom_req), .rom_addr(rom_addr), .rom_valid(rom_valid), .rom_data(rom_data),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
      .wr_be(wr_be), .busy(busy), .done(done), .err(err)
   );

   always #10 clk = ~clk;

   logic [7:0]  mem [0:4095];
   logic [31:0] cap_addr [0:299];
   logic [31:0] cap_data [0:299];
   logic [3:0]  cap_be   [0:299];

   int nchk = 0;
   int nfail = 0;
   int ncap, nrd, ndone, novl, nhold, tick;
   logic rpend, stall_mode, prev_stall;
   int rcnt;
   logic [AW-1:0] raddr;
   logic [31:0] p_addr, p_data;
   logic [3:0]  p_be;

   // EEPROM model, write sink and monitors; all cleared during reset
   always @(posedge clk) begin
      if (!rst_n) begin
         rom_valid <= 1'b0; rpend <= 1'b0; rcnt <= 0;
         ncap <= 0; nrd <= 0; ndone <= 0; novl <= 0; nhold <= 0;
         tick <= 0; prev_stall <= 1'b0; wr_ready <= 1'b1;
      end else begin
         rom_valid <= 1'b0;
         tick <= tick + 1;
         if (rpend) begin
            if (rcnt == 0) begin
               rom_valid <= 1'b1;
               rom_data  <= mem[raddr[11:0]];
               rpend     <= 1'b0;
            end else rcnt <= rcnt - 1;
         end
         if (rom_req) begin
            if (rpend) novl <= novl + 1;
            rpend <= 1'b1; rcnt <= 1; raddr <= rom_addr; nrd <= nrd + 1;
         end
         if (done) ndone <= ndone + 1;
         if (wr_valid && wr_ready && ncap < 300) begin
            cap_addr[ncap] <= wr_addr; cap_data[ncap] <= wr_data; cap_be[ncap] <= wr_be;
            ncap <= ncap + 1;
         end
         if (prev_stall && !(wr_valid && wr_addr == p_addr && wr_data == p_data && wr_be == p_be))
            nhold <= nhold + 1;
         prev_stall <= wr_valid && !wr_ready;
         p_addr <= wr_addr; p_data <= wr_data; p_be <= wr_be;
         wr_ready <= stall_mode ? ((tick % 3) == 2) : 1'b1;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
   endtask

   task automatic put32(input int a, input logic [31:0] v);
      mem[a] = v[31:24]; mem[a+1] = v[23:16]; mem[a+2] = v[15:8]; mem[a+3] = v[7:0];
   endtask

   task automatic put_rec(input int ptr, input int idx, input logic [31:0] a,
                          input logic [31:0] d, input logic [31:0] c);
      put32(ptr + 12*idx, a); put32(ptr + 12*idx + 4, d); put32(ptr + 12*idx + 8, c);
   endtask

   task automatic start_run(input logic en, input logic stall, input bit chk_reset);
      @(negedge clk);
      rst_n = 1'b0; autoload_en = en; stall_mode = stall;
      repeat (3) @(negedge clk);
      if (chk_reset)
         check(!busy && !done && !err && !wr_valid && !rom_req, "R10", "outputs idle in reset",
               {27'd0, busy, done, err, wr_valid, rom_req}, 32'd0);
      rst_n = 1'b1;
   endtask

   task automatic wait_done(input int limit);
      for (int i = 0; i < limit; i++) begin
         @(negedge clk);
         if (ndone > 0) break;
      end
      repeat (20) @(negedge clk);
   endtask

   task automatic basic_table();
      clear_mem();
      put32(4, 32'h0000_0200);
      put_rec(32'h200, 0, 32'h1000_0001, 32'hA1B2_C3D4, 32'h0000_0000);
      put_rec(32'h200, 1, 32'hF000_0102, 32'h1122_3344, 32'h0000_0001);
      put_rec(32'h200, 2, 32'h8000_0000, 32'hCAFE_F00D, 32'h0000_0001);
      put_rec(32'h200, 3, 32'h0000_0F07, 32'h5566_7788, 32'h0000_0000);
      put_rec(32'h200, 4, 32'h0000_0F04, 32'h0BAD_0BAD, 32'h0000_0003);
      put_rec(32'h200, 5, 32'h1234_5679, 32'hDEAD_BEEF, 32'h8000_0002);
      put_rec(32'h200, 6, 32'h9999_9999, 32'h7777_7777, 32'h8000_0002);
   endtask

   task automatic t_disabled();
      clear_mem();
      put32(4, 32'h0000_0100);
      start_run(1'b0, 1'b0, 1'b1);
      wait_done(100);
      check(ndone == 1, "R1", "done pulses", ndone, 1);
      check(nrd == 0, "R1", "no EEPROM reads", nrd, 0);
      check(ncap == 0 && err == 1'b0, "R1", "no writes, no error", ncap, 0);
   endtask

   task automatic t_basic();
      logic [31:0] ea [0:5];
      logic [31:0] ed [0:5];
      logic [3:0]  eb [0:5];
      ea = '{32'h1000_0001, 32'hF000_0102, 32'h8000_0000, 32'h0000_0F07, 32'h0000_0F04, 32'h1234_5679};
      ed = '{32'hA1B2_C3D4, 32'h1122_3344, 32'hCAFE_F00D, 32'h5566_7788, 32'h0BAD_0BAD, 32'hDEAD_BEEF};
      eb = '{4'b0010, 4'b1100, 4'b0011, 4'b1000, 4'b1111, 4'b1111};
      basic_table();
      start_run(1'b1, 1'b1, 1'b0);
      repeat (10) @(negedge clk);
      check(busy == 1'b1, "R5", "busy during walk", busy, 1);
      wait_done(5000);
      check(ncap == 6, "R5", "write count stops at final record", ncap, 6);
      for (int i = 0; i < 6; i++) begin
         check(cap_addr[i] == ea[i], "R3", "record address", cap_addr[i], ea[i]);
         check(cap_data[i] == ed[i], "R3", "record data", cap_data[i], ed[i]);
         check(cap_be[i] == eb[i], "R4", "byte enables", cap_be[i], eb[i]);
      end
      check(nrd == 4 + 6*12, "R2", "pointer plus record reads only", nrd, 4 + 6*12);
      check(ndone == 1 && !err && !busy, "R5", "single done, no error, idle", ndone, 1);
      check(novl == 0, "R9", "one outstanding read", novl, 0);
      check(nhold == 0, "R8", "stalled write held", nhold, 0);
   endtask

   task automatic t_bad_ptr();
      clear_mem();
      put32(4, 32'h0000_003C);
      put_rec(32'h3C, 0, 32'h4444_0000, 32'h1, 32'h8000_0002);
      start_run(1'b1, 1'b0, 1'b0);
      wait_done(1000);
      check(err == 1'b1, "R6", "error on reserved pointer", err, 1);
      check(ncap == 0 && ndone == 1, "R6", "no writes, done once", ncap, 0);
      clear_mem();
      put32(4, 32'h0000_0040);
      put_rec(32'h40, 0, 32'h4444_0000, 32'h0000_0001, 32'h8000_0002);
      start_run(1'b1, 1'b0, 1'b0);
      wait_done(1000);
      check(err == 1'b0 && ncap == 1, "R6", "pointer at boundary accepted", ncap, 1);
   endtask

   task automatic t_limit(input bit last_on_final);
      int bad;
      clear_mem();
      put32(4, 32'h0000_0100);
      for (int i = 0; i < 260; i++)
         put_rec(32'h100, i, 32'h2000_0000 + 32'(4*i), 32'h0101_0101 * 32'(i + 1),
                 (last_on_final && i == 255) ? 32'h8000_0002 : 32'h0000_0002);
      start_run(1'b1, 1'b0, 1'b0);
      wait_done(60000);
      check(ncap == 256, "R7", "writes up to the limit", ncap, 256);
      bad = 0;
      for (int i = 0; i < 256; i++)
         if (cap_addr[i] != 32'h2000_0000 + 32'(4*i) || cap_data[i] != 32'h0101_0101 * 32'(i + 1))
            bad++;
      check(bad == 0, "R7", "limit table contents", bad, 0);
      if (last_on_final)
         check(err == 1'b0 && ndone == 1, "R7", "final flag on last allowed record", err, 0);
      else
         check(err == 1'b1 && ndone == 1, "R7", "runaway table flagged", err, 1);
   endtask

   task automatic t_reset_mid();
      basic_table();
      start_run(1'b1, 1'b0, 1'b0);
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         if (ncap >= 2) break;
      end
      start_run(1'b1, 1'b0, 1'b1);
      wait_done(5000);
      check(ncap == 6 && cap_addr[0] == 32'h1000_0001, "R10", "walk restarts after reset",
            cap_addr[0], 32'h1000_0001);
      check(cap_data[5] == 32'hDEAD_BEEF && !err, "R10", "complete walk after restart",
            cap_data[5], 32'hDEAD_BEEF);
   endtask

   initial begin
      stall_mode = 1'b0;
      t_disabled();
      t_basic();
      t_bad_ptr();
      t_limit(1'b1);
      t_limit(1'b0);
      t_reset_mid();
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (180000) @(posedge clk);
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

endmodule